// File: doc/BRIEF.md
# Paged Monochrome Display RAM Controller

This block holds the pixel memory of a monochrome graphic panel driver. The memory has 65 rows and 132 columns, one bit per pixel. A host reaches it one byte at a time. It first picks a page and a column with command bytes, and then reads or writes one data byte. Each data byte covers eight vertically stacked pixels in one column. The first 64 rows form eight full pages of eight rows each. A short ninth page holds only the last row.

On the display side, a line scanner emits one full horizontal row of pixels on every clock. It steps through the 64 main rows and then the extra row, over and over. The main rows are read starting from a programmable start line and wrap modulo 64, which gives vertical scrolling. A direction bit can mirror the column order on the segment outputs.

Top module: `glcd_frame_mem`

## Requirements
- R1: A data write with page p and column c stores data bit k into memory row 8*p+k of column c. For example, page 1 bit 0 goes to row 8 and page 1 bit 7 goes to row 15.
- R2: A data read is flagged by `host_dc`=1 and `host_rd`=1. One clock later it raises `rd_valid` for one cycle and presents the addressed byte on `rd_data`, using the same bit-to-row mapping as writes. `rd_data` holds its value until the next read.
- R3: Page 8 holds only row 64. A write there stores data bit 0 alone, and a read there returns bits 7..1 as zero.
- R4: A page number of 9 to 15 is invalid. A write to it changes no pixel, and a read from it returns 0x00.
- R5: Command 0001hhhh loads the upper nibble of the 8-bit column address, and command 0000llll loads the lower nibble. A column above 131 is invalid: a write there is dropped, a read there returns 0x00, and the column does not advance.
- R6: After each data read or write at a valid column, the column advances by one. It saturates at 131. The page never changes as a result of a data access.
- R7: Command 01ssssss sets the 6-bit start line s. Display row r, for r from 0 to 63, shows memory row (s+r) mod 64.
- R8: Display row 64 always shows memory row 64, whatever the start line is.
- R9: Command 1010000d sets the segment direction d. With d=0, segment i shows column i. With d=1, segment i shows column 131-i.
- R10: `scan_row` counts 0, 1, ..., 64 and then returns to 0, one step per clock. `scan_pix` carries the pixels of the row named by `scan_row` in the same cycle.
- R11: While reset is held, page, column and start line are 0 and the direction bit is 0. All pixels are cleared, `rd_valid` and `rd_data` are 0, `scan_pix` is all zero and `scan_row` is 64.
- R12: Command 1011pppp loads the 4-bit page. Any other command byte changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host byte transfer in this cycle |
| host_dc | input | 1 | 1 = data byte, 0 = command byte |
| host_rd | input | 1 | With host_dc=1: 1 = read, 0 = write |
| host_wdata | input | 8 | Command or write data byte |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | rd_data was updated by a read in the previous cycle |
| scan_row | output | 7 | Display row index now on scan_pix |
| scan_pix | output | 132 | Pixels of the current display row, one per segment |

## Verification
The bench builds the block with its default sizes: 132 columns and eight full pages. This keeps the real column limit of 131 and the short ninth page within reach. The saturation at the last column, the dropped access at column 132, the single-bit page 8, and the invalid pages 9 and above are all driven directly. Every clock, a behavioural model compares the full 132-bit row and its index, under scrolled start lines and mirrored segment order. This includes the row-64 exception and the wrap from row 64 back to row 0.

// File: rtl/glcd_pkg.sv
package glcd_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_COL_LO, CMD_COL_HI, CMD_START, CMD_PAGE, CMD_SEGDIR
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic [7:0] b);
    if (b[7:4] == 4'b0000)      return CMD_COL_LO;
    else if (b[7:4] == 4'b0001) return CMD_COL_HI;
    else if (b[7:6] == 2'b01)   return CMD_START;
    else if (b[7:4] == 4'b1011) return CMD_PAGE;
    else if (b[7:1] == 7'b1010000) return CMD_SEGDIR;
    else return CMD_NONE;
  endfunction

  // memory row feeding display row r
  function automatic int scan_src_row(input int start, input int r, input int main_rows);
    if (r >= main_rows) return main_rows;
    return (start + r) % main_rows;
  endfunction

  // column shown on segment s
  function automatic int seg_to_col(input int s, input logic rev, input int ncols);
    return rev ? (ncols - 1 - s) : s;
  endfunction
endpackage

// File: rtl/glcd_cmd_regs.sv
module glcd_cmd_regs #(
  parameter int NCOLS = 132,
  parameter int SL_W  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_fire,
  input  logic [7:0]      cmd_byte,
  input  logic            acc_fire,
  output logic [7:0]      col_q,
  output logic [3:0]      page_q,
  output logic [SL_W-1:0] start_q,
  output logic            rev_q
);
  import glcd_pkg::*;

  cmd_e kind;
  assign kind = decode_cmd(cmd_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      page_q  <= '0;
      start_q <= '0;
      rev_q   <= 1'b0;
    end else begin
      if (cmd_fire) begin
        case (kind)
          CMD_COL_LO: col_q[3:0] <= cmd_byte[3:0];
          CMD_COL_HI: col_q[7:4] <= cmd_byte[3:0];
          CMD_START:  start_q    <= cmd_byte[SL_W-1:0];
          CMD_PAGE:   page_q     <= cmd_byte[3:0];
          CMD_SEGDIR: rev_q      <= cmd_byte[0];
          default: ;
        endcase
      end
      if (acc_fire && (int'(col_q) < NCOLS - 1))
        col_q <= col_q + 8'd1;
    end
  end
endmodule

// File: rtl/glcd_pixel_array.sv
module glcd_pixel_array #(
  parameter int NCOLS      = 132,
  parameter int MAIN_PAGES = 8,
  parameter int NROWS      = 65,
  parameter int ROW_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [3:0]       page_i,
  input  logic [7:0]       col_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             page_ok_o,
  output logic             col_ok_o,
  input  logic [ROW_W-1:0] scan_idx_i,
  output logic [NCOLS-1:0] scan_bits_o
);
  import glcd_pkg::*;

  logic [NCOLS-1:0] mem [NROWS];
  logic [DW-1:0]    bit_hit;
  logic [ROW_W-1:0] bit_row [DW];
  logic [7:0]       rd_byte;

  assign page_ok_o = (int'(page_i) <= MAIN_PAGES);
  assign col_ok_o  = (int'(col_i) < NCOLS);

  always_comb begin
    for (int k = 0; k < DW; k++) begin
      bit_hit[k] = page_ok_o && col_ok_o && ((int'(page_i) * DW + k) < NROWS);
      bit_row[k] = ROW_W'(int'(page_i) * DW + k);
      rd_byte[k] = bit_hit[k] ? mem[bit_row[k]][col_i] : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NROWS; r++) mem[r] <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < DW; k++)
        if (bit_hit[k]) mem[bit_row[k]][col_i] <= wdata_i[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en;
      if (rd_en) rd_data_o <= rd_byte;
    end
  end

  assign scan_bits_o = mem[scan_idx_i];
endmodule

// File: rtl/glcd_line_scan.sv
module glcd_line_scan #(
  parameter int NCOLS     = 132,
  parameter int MAIN_ROWS = 64,
  parameter int ROW_W     = 7,
  parameter int SL_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SL_W-1:0]  start_i,
  input  logic             rev_i,
  input  logic [NCOLS-1:0] row_bits_i,
  output logic [ROW_W-1:0] scan_idx_o,
  output logic [ROW_W-1:0] scan_row_o,
  output logic [NCOLS-1:0] scan_pix_o
);
  import glcd_pkg::*;

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(MAIN_ROWS);

  logic [ROW_W-1:0] next_row;
  logic [NCOLS-1:0] pix_n;

  assign next_row   = (scan_row_o == LAST_ROW) ? '0 : scan_row_o + 1'b1;
  assign scan_idx_o = ROW_W'(scan_src_row(int'(start_i), int'(next_row), MAIN_ROWS));

  always_comb begin
    for (int s = 0; s < NCOLS; s++)
      pix_n[s] = row_bits_i[seg_to_col(s, rev_i, NCOLS)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_row_o <= LAST_ROW;
      scan_pix_o <= '0;
    end else begin
      scan_row_o <= next_row;
      scan_pix_o <= pix_n;
    end
  end
endmodule

// File: rtl/glcd_frame_mem.sv
module glcd_frame_mem #(
  parameter int NCOLS      = 132,
  parameter int MAIN_PAGES = 8
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           host_valid,
  input  logic                                           host_dc,
  input  logic                                           host_rd,
  input  logic [7:0]                                     host_wdata,
  output logic [7:0]                                     rd_data,
  output logic                                           rd_valid,
  output logic [$clog2(MAIN_PAGES*glcd_pkg::DW+1)-1:0]   scan_row,
  output logic [NCOLS-1:0]                               scan_pix
);
  localparam int MAIN_ROWS = MAIN_PAGES * glcd_pkg::DW;
  localparam int NROWS     = MAIN_ROWS + 1;
  localparam int ROW_W     = $clog2(NROWS);
  localparam int SL_W      = $clog2(MAIN_ROWS);

  // named internal events
  logic cmd_fire, wr_fire, rd_fire, acc_fire;
  logic page_ok, col_ok;
  logic [7:0]       col_q;
  logic [3:0]       page_q;
  logic [SL_W-1:0]  start_q;
  logic             rev_q;
  logic [ROW_W-1:0] scan_idx;
  logic [NCOLS-1:0] row_bits;

  assign cmd_fire = host_valid && !host_dc;
  assign wr_fire  = host_valid && host_dc && !host_rd;
  assign rd_fire  = host_valid && host_dc && host_rd;
  assign acc_fire = wr_fire || rd_fire;

  glcd_cmd_regs #(.NCOLS(NCOLS), .SL_W(SL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_byte(host_wdata),
    .acc_fire(acc_fire), .col_q(col_q), .page_q(page_q), .start_q(start_q),
    .rev_q(rev_q)
  );

  glcd_pixel_array #(.NCOLS(NCOLS), .MAIN_PAGES(MAIN_PAGES), .NROWS(NROWS),
                     .ROW_W(ROW_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .rd_en(rd_fire),
    .page_i(page_q), .col_i(col_q), .wdata_i(host_wdata),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .page_ok_o(page_ok), .col_ok_o(col_ok),
    .scan_idx_i(scan_idx), .scan_bits_o(row_bits)
  );

  glcd_line_scan #(.NCOLS(NCOLS), .MAIN_ROWS(MAIN_ROWS), .ROW_W(ROW_W),
                   .SL_W(SL_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .start_i(start_q), .rev_i(rev_q),
    .row_bits_i(row_bits), .scan_idx_o(scan_idx), .scan_row_o(scan_row),
    .scan_pix_o(scan_pix)
  );
endmodule

// File: rtl/glcd_frame_mem_chk.sv
module glcd_frame_mem_chk #(
  parameter int NCOLS = 132,
  parameter int NROWS = 65,
  parameter int ROW_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_fire,
  input logic             acc_fire,
  input logic             page_ok,
  input logic             col_ok,
  input logic [7:0]       col_q,
  input logic [3:0]       page_q,
  input logic [7:0]       rd_data,
  input logic             rd_valid,
  input logic [ROW_W-1:0] scan_row
);
  assert_rd_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_valid);
  assert_rd_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rd_valid);
  assert_bad_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !page_ok) |=> (rd_data == 8'h00));
  assert_bad_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !col_ok) |=> $stable(col_q));
  assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> $stable(page_q));
  assert_col_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && int'(col_q) == NCOLS - 1) |=> (int'(col_q) == NCOLS - 1));
  assert_scan_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(scan_row) == NROWS - 1) |=> (scan_row == '0));
  assert_scan_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(scan_row) < NROWS - 1) |=> (scan_row == $past(scan_row) + 1'b1));
endmodule

bind glcd_frame_mem glcd_frame_mem_chk #(.NCOLS(NCOLS), .NROWS(NROWS), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .acc_fire(acc_fire),
  .page_ok(page_ok), .col_ok(col_ok), .col_q(col_q), .page_q(page_q),
  .rd_data(rd_data), .rd_valid(rd_valid), .scan_row(scan_row)
);

// File: tb/tb_glcd_frame_mem.sv
`timescale 1ns/1ps
module tb_glcd_frame_mem;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 1'b0, host_dc = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] rd_data;
  logic rd_valid;
  logic [6:0] scan_row;
  logic [131:0] scan_pix;

  always #5 clk = ~clk;

  glcd_frame_mem dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_dc(host_dc),
    .host_rd(host_rd), .host_wdata(host_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .scan_row(scan_row), .scan_pix(scan_pix)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit started = 0, done = 0;

  task automatic check(input bit ok, input string req, input logic [131:0] act,
                       input logic [131:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference
  bit mm [0:64][0:131];
  int m_col, m_page, m_start, m_srow;
  bit m_rev;
  logic [7:0] e_rd;
  bit e_val;
  logic [131:0] e_pix;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      foreach (mm[r, c]) mm[r][c] = 0;
      m_col = 0; m_page = 0; m_start = 0; m_rev = 0; m_srow = 64;
      e_rd = 0; e_val = 0; e_pix = '0;
      started = 1;
    end else begin
      m_srow = (m_srow == 64) ? 0 : m_srow + 1;
      for (int s = 0; s < 132; s++) begin
        int r;
        int c;
        c = m_rev ? 131 - s : s;
        r = (m_srow == 64) ? 64 : (m_start + m_srow) % 64;
        e_pix[s] = mm[r][c];
      end
      e_val = 0;
      if (host_valid && !host_dc) begin
        casez (host_wdata)
          8'b0000????: m_col = (m_col & 8'hF0) | host_wdata[3:0];
          8'b0001????: m_col = (m_col & 8'h0F) | (host_wdata[3:0] << 4);
          8'b01??????: m_start = host_wdata[5:0];
          8'b1011????: m_page = host_wdata[3:0];
          8'b1010000?: m_rev = host_wdata[0];
          default: ;
        endcase
      end else if (host_valid) begin
        bit ok;
        ok = (m_col <= 131) && (m_page <= 8);
        if (host_rd) begin
          e_val = 1;
          e_rd = 0;
        end
        for (int k = 0; k < 8; k++) begin
          int r;
          r = m_page * 8 + k;
          if (ok && r < 65) begin
            if (host_rd) e_rd[k] = mm[r][m_col];
            else mm[r][m_col] = host_wdata[k];
          end
        end
        if (m_col < 131) m_col++;
      end
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      check(rd_valid == e_val, "R2 rd_valid", 132'(rd_valid), 132'(e_val));
      check(rd_data == e_rd, "R2 rd_data", 132'(rd_data), 132'(e_rd));
      check(int'(scan_row) == m_srow, "R10 scan_row", 132'(scan_row), 132'(m_srow));
      check(scan_pix == e_pix, "R7/R9 scan_pix", scan_pix, e_pix);
    end
  end

  task automatic cmd(input logic [7:0] b);
    host_valid = 1; host_dc = 0; host_rd = 0; host_wdata = b;
    @(negedge clk);
    host_valid = 0;
  endtask

  task automatic wr(input logic [7:0] b);
    host_valid = 1; host_dc = 1; host_rd = 0; host_wdata = b;
    @(negedge clk);
    host_valid = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    host_valid = 1; host_dc = 1; host_rd = 1; host_wdata = 8'h00;
    @(negedge clk);
    host_valid = 0;
    v = rd_data;
  endtask

  task automatic set_col(input int c);
    cmd(8'h10 | 8'(c >> 4));
    cmd(8'h00 | 8'(c & 15));
  endtask

  task automatic wait_row(input int n);
    for (int i = 0; i < 80; i++) begin
      if (int'(scan_row) == n) break;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(rd_data == 0 && rd_valid == 0, "R11 host outputs", 132'(rd_data), 0);
    check(scan_pix == '0 && scan_row == 7'd64, "R11 scan outputs", 132'(scan_row), 64);
    rst_n = 1;
    @(negedge clk);

    // R1 write page 1, col 5 and 6; R6 increment
    cmd(8'hB1); set_col(5);
    wr(8'hA5); wr(8'h3C);
    set_col(5);
    rd(v); check(v == 8'hA5, "R1 readback col5", 132'(v), 132'hA5);
    rd(v); check(v == 8'h3C, "R6 auto increment", 132'(v), 132'h3C);
    wait_row(8);  check(scan_pix[5] == 1'b1, "R1 row8 bit0", 132'(scan_pix[5]), 1);
    wait_row(15); check(scan_pix[5] == 1'b1, "R1 row15 bit7", 132'(scan_pix[5]), 1);
    wait_row(9);  check(scan_pix[5] == 1'b0, "R1 row9 bit1", 132'(scan_pix[5]), 0);

    // R3 page 8 single row
    cmd(8'hB8); set_col(0); wr(8'hFF);
    set_col(0); rd(v); check(v == 8'h01, "R3 page8 readback", 132'(v), 1);
    wait_row(64); check(scan_pix[0] == 1'b1, "R8 row64", 132'(scan_pix[0]), 1);

    // R7 scroll, R8 unaffected
    cmd(8'h40 | 8'd5);
    @(negedge clk);
    wait_row(3);  check(scan_pix[5] == 1'b1, "R7 scrolled row", 132'(scan_pix[5]), 1);
    wait_row(64); check(scan_pix[0] == 1'b1, "R8 row64 under scroll", 132'(scan_pix[0]), 1);
    cmd(8'h40);

    // R4 invalid page
    cmd(8'hB9); set_col(0); wr(8'hFF);
    set_col(0); rd(v); check(v == 8'h00, "R4 bad page read", 132'(v), 0);

    // R5 invalid column, R6 saturation
    cmd(8'hB1); set_col(132); wr(8'hFF);
    rd(v); check(v == 8'h00, "R5 bad column read", 132'(v), 0);
    set_col(131); wr(8'h77); wr(8'h11);
    set_col(131);
    rd(v); check(v == 8'h11, "R6 saturate", 132'(v), 132'h11);
    rd(v); check(v == 8'h11, "R6 saturate hold", 132'(v), 132'h11);

    // R9 mirrored segments
    cmd(8'hA1);
    @(negedge clk);
    wait_row(8);
    check(scan_pix[126] == 1'b1, "R9 mirrored on", 132'(scan_pix[126]), 1);
    check(scan_pix[5] == 1'b0, "R9 mirrored off", 132'(scan_pix[5]), 0);
    cmd(8'hA0);

    // R12 unknown command keeps page
    cmd(8'hB1); set_col(5); cmd(8'hFF); cmd(8'hE3);
    rd(v); check(v == 8'hA5, "R12 page kept", 132'(v), 132'hA5);

    // R10 wrap
    wait_row(64); @(negedge clk);
    check(scan_row == 7'd0, "R10 wrap", 132'(scan_row), 0);

    repeat (70) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule